// File: doc/BRIEF.md
# Slow-to-Fast Counter Transfer

This block carries a 32-bit count and a match event from a slow counting clock into a much faster bus clock. The two clocks may be unrelated in phase and frequency. The only condition is that the bus clock runs more than three times faster than the slow clock. The bus side sees a copy of the count that changes only to whole, settled values. It also sees a one-cycle pulse for every match event raised in the slow domain.

On the slow side, the block keeps a held copy of the count. Each time the count moves, the held copy is updated and a single toggle bit flips. Match events flip a second toggle bit. Each toggle crosses into the bus domain through a multi-flop synchronizer. A detected toggle edge then either samples the held word or produces a match pulse. By the time the edge is seen, the held word has been stable for at least one bus cycle. The clock ratio keeps it stable until it has been sampled. Any interrupt status built on top of this block, raw or masked, is derived from the bus-side match pulse.

Top module: `slow_cnt_xfer`

## Requirements
- R1: While the bus reset is low, `cnt_o` is zero and `match_pulse_o` is low. After both resets release, `cnt_o` stays zero until `cnt_i` first differs from zero at a slow clock edge.
- R2: A new `cnt_i` value sampled at a slow clock edge appears on `cnt_o` within SYNC_N+2 bus cycles.
- R3: `cnt_o` only ever takes a value that `cnt_i` presented, with no mixture of old and new bits. It changes only on a captured toggle edge, and the captured word has been stable for at least one bus cycle.
- R4: With the clock ratio above three, a count that changes on every slow edge is delivered in full. Every value appears on `cnt_o` in order, none is skipped, and each change is one step up.
- R5: Each slow clock edge at which `match_i` is high produces exactly one `match_pulse_o`. This holds on consecutive edges and when the count does not change.
- R6: `match_pulse_o` is high for exactly one bus cycle per event.
- R7: A step from all ones to zero is treated as a change and delivered like any other value.
- R8: The slow reset `slow_rst_ni` acts asynchronously. It clears the held word and both toggle bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk_i | input | 1 | Slow counting clock |
| slow_rst_ni | input | 1 | Active-low asynchronous reset, slow domain |
| cnt_i | input | CNT_W | Count value, slow domain |
| match_i | input | 1 | Match event, sampled on each slow edge |
| bus_clk_i | input | 1 | Fast bus clock |
| bus_rst_ni | input | 1 | Active-low asynchronous reset, bus domain |
| cnt_o | output | CNT_W | Settled bus-domain copy of the count |
| match_pulse_o | output | 1 | One-cycle bus-domain match pulse |

## Verification
A vector table applies isolated count values: alternating bit patterns, the top bit alone, all ones followed by zero, and a repeat of the previous value together with a match. These show whether each change is captured as a whole word, and whether a match without a count change still gives exactly one pulse. A long run that increments on every slow edge, starting near the wrap, separates a design that keeps up under the minimum clock ratio from one that drops or tears values. A burst of back-to-back match edges tells whether one pulse is produced per event, rather than one per burst or one stretched pulse. A reset sequence with the count held at zero confirms that the copy stays at zero until the first real change.

// File: rtl/slow_cnt_xfer_pkg.sv
package slow_cnt_xfer_pkg;
  localparam int unsigned DEF_CNT_W  = 32;
  localparam int unsigned DEF_SYNC_N = 2;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cs_slow_src.sv
module cs_slow_src #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         match_i,
  output logic [W-1:0] held_o,
  output logic         cnt_tog_o,
  output logic         match_tog_o
);
  logic [W-1:0] held_q;
  logic         ctog_q, mtog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      ctog_q <= 1'b0;
      mtog_q <= 1'b0;
    end else begin
      if (cnt_i != held_q) begin
        held_q <= cnt_i;
        ctog_q <= ~ctog_q;
      end
      if (match_i) mtog_q <= ~mtog_q;
    end
  end

  assign held_o      = held_q;
  assign cnt_tog_o   = ctog_q;
  assign match_tog_o = mtog_q;

  // held word may only move together with a toggle flip
  AST_HELD_WITH_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(held_q) |-> !$stable(ctog_q));  // R3
endmodule

// File: rtl/cs_bus_sink.sv
module cs_bus_sink #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] held_i,
  input  logic         cnt_tog_i,
  input  logic         match_tog_i,
  output logic [W-1:0] cnt_o,
  output logic         match_pulse_o
);
  logic ctog_s, mtog_s;
  logic ctog_p, mtog_p;
  logic cap_en;
  logic [W-1:0] cnt_q;
  logic         pulse_q;

  cs_sync #(.STAGES(STAGES)) i_cnt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_tog_i), .q_o(ctog_s));
  cs_sync #(.STAGES(STAGES)) i_match_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(match_tog_i), .q_o(mtog_s));

  assign cap_en = ctog_s ^ ctog_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctog_p  <= 1'b0;
      mtog_p  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      ctog_p  <= ctog_s;
      mtog_p  <= mtog_s;
      pulse_q <= mtog_s ^ mtog_p;
      if (cap_en) cnt_q <= held_i;
    end
  end

  assign cnt_o         = cnt_q;
  assign match_pulse_o = pulse_q;

  AST_CAPTURE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |-> held_i == $past(held_i));  // R3
  AST_COPY_ON_EDGE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> $past(cap_en));  // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);  // R6
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt_q == '0 && !pulse_q));  // R1
endmodule

// File: rtl/slow_cnt_xfer.sv
module slow_cnt_xfer
  import slow_cnt_xfer_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic             slow_clk_i,
  input  logic             slow_rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             match_i,
  input  logic             bus_clk_i,
  input  logic             bus_rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_pulse_o
);
  logic [CNT_W-1:0] held;
  logic             cnt_tog, match_tog;

  cs_slow_src #(.W(CNT_W)) i_src (
    .clk_i       (slow_clk_i),
    .rst_ni      (slow_rst_ni),
    .cnt_i       (cnt_i),
    .match_i     (match_i),
    .held_o      (held),
    .cnt_tog_o   (cnt_tog),
    .match_tog_o (match_tog)
  );

  cs_bus_sink #(.W(CNT_W), .STAGES(SYNC_N)) i_sink (
    .clk_i         (bus_clk_i),
    .rst_ni        (bus_rst_ni),
    .held_i        (held),
    .cnt_tog_i     (cnt_tog),
    .match_tog_i   (match_tog),
    .cnt_o         (cnt_o),
    .match_pulse_o (match_pulse_o)
  );
endmodule

// File: tb/test_slow_cnt_xfer.sv
`timescale 1ns/1ps
module test_slow_cnt_xfer;
  logic        bus_clk, slow_clk;
  logic        bus_rst_n, slow_rst_n;
  logic [31:0] cnt_in;
  logic        match_in;
  logic [31:0] cnt_out;
  logic        pulse;

  int checks = 0;
  int fails  = 0;

  slow_cnt_xfer i_slow_cnt_xfer (
    .slow_clk_i(slow_clk), .slow_rst_ni(slow_rst_n), .cnt_i(cnt_in),
    .match_i(match_in), .bus_clk_i(bus_clk), .bus_rst_ni(bus_rst_n),
    .cnt_o(cnt_out), .match_pulse_o(pulse));

  initial begin bus_clk = 1'b0; forever #4 bus_clk = ~bus_clk; end
  initial begin slow_clk = 1'b0; #3; forever #18.5 slow_clk = ~slow_clk; end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitors
  logic [31:0] tb_cur = 32'h0, tb_prev = 32'h0, last_o = 32'h0;
  bit          inc_mode = 1'b0;
  int          inc_changes = 0;
  int          pulse_hi = 0, pulse_rise = 0;
  logic        pulse_d = 1'b0;

  always @(negedge bus_clk) begin
    if (bus_rst_n === 1'b1) begin
      if (cnt_out !== last_o) begin
        chk(cnt_out === tb_cur || cnt_out === tb_prev, "R3 whole value", cnt_out, tb_cur);
        if (inc_mode) begin
          chk(cnt_out === last_o + 32'd1, "R4 step", cnt_out, last_o + 32'd1);
          inc_changes++;
        end
        last_o = cnt_out;
      end
      if (pulse === 1'b1) pulse_hi++;
      if (pulse === 1'b1 && pulse_d !== 1'b1) pulse_rise++;
      pulse_d = pulse;
    end else begin
      last_o  = 32'h0;
      pulse_d = 1'b0;
    end
  end

  // bit 32 = match flag, bits 31:0 = count value
  localparam logic [32:0] VEC [9] = '{
    {1'b1, 32'h0000_0001},
    {1'b0, 32'h0000_0002},
    {1'b1, 32'hA5A5_A5A5},
    {1'b0, 32'h5A5A_5A5A},
    {1'b1, 32'hFFFF_FFFF},
    {1'b0, 32'h0000_0000},
    {1'b1, 32'h8000_0000},
    {1'b0, 32'h7FFF_FFFF},
    {1'b1, 32'h7FFF_FFFF}
  };

  task automatic do_reset();
    @(negedge slow_clk);
    cnt_in = 32'h0; match_in = 1'b0;
    tb_cur = 32'h0; tb_prev = 32'h0;
    bus_rst_n = 1'b0; slow_rst_n = 1'b0;
    repeat (3) @(negedge slow_clk);
    @(negedge bus_clk);
    chk(cnt_out === 32'h0, "R1 reset copy", cnt_out, 32'h0);
    chk(pulse === 1'b0, "R1 reset pulse", {31'h0, pulse}, 32'h0);
    @(negedge slow_clk) slow_rst_n = 1'b1;
    @(negedge bus_clk) bus_rst_n = 1'b1;
  endtask

  initial begin
    int r0, h0;
    cnt_in = 32'h0; match_in = 1'b0;
    bus_rst_n = 1'b0; slow_rst_n = 1'b0;
    do_reset();

    // R1: stays zero while count remains zero
    repeat (20) @(negedge slow_clk);
    chk(cnt_out === 32'h0, "R1 hold zero", cnt_out, 32'h0);
    chk(pulse_rise == 0, "R1 no pulse", pulse_rise, 0);

    // vector table: R2, R3, R5, R7
    foreach (VEC[i]) begin
      r0 = pulse_rise;
      @(negedge slow_clk);
      tb_prev = tb_cur; tb_cur = VEC[i][31:0];
      cnt_in = VEC[i][31:0]; match_in = VEC[i][32];
      @(negedge slow_clk) match_in = 1'b0;
      repeat (2) @(negedge slow_clk);
      @(negedge bus_clk);
      chk(cnt_out === VEC[i][31:0], (VEC[i][31:0] == 32'h0) ? "R7 wrap" : "R2 delivered",
          cnt_out, VEC[i][31:0]);
      chk(pulse_rise - r0 == int'(VEC[i][32]), "R5 match count", pulse_rise - r0, int'(VEC[i][32]));
    end

    // R5, R6: back-to-back match edges
    r0 = pulse_rise; h0 = pulse_hi;
    @(negedge slow_clk) match_in = 1'b1;
    repeat (6) @(negedge slow_clk);
    match_in = 1'b0;
    repeat (3) @(negedge slow_clk);
    chk(pulse_rise - r0 == 6, "R5 burst pulses", pulse_rise - r0, 6);
    chk(pulse_hi - h0 == 6, "R6 pulse width", pulse_hi - h0, 6);

    // R4, R7: increment every slow edge across the wrap
    @(negedge slow_clk);
    tb_prev = tb_cur; tb_cur = 32'hFFFF_FF80; cnt_in = 32'hFFFF_FF80;
    repeat (3) @(negedge slow_clk);
    @(negedge bus_clk);
    chk(cnt_out === 32'hFFFF_FF80, "R2 start value", cnt_out, 32'hFFFF_FF80);
    inc_mode = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge slow_clk);
      tb_prev = tb_cur; tb_cur = tb_cur + 32'd1; cnt_in = tb_cur;
    end
    repeat (3) @(negedge slow_clk);
    @(negedge bus_clk);
    inc_mode = 1'b0;
    chk(inc_changes == 300, "R4 all delivered", inc_changes, 300);
    chk(cnt_out === 32'hFFFF_FF80 + 32'd300, "R7 after wrap", cnt_out, 32'hFFFF_FF80 + 32'd300);

    // R8: slow reset clears held word; R1 after full reset
    do_reset();
    repeat (10) @(negedge slow_clk);
    chk(cnt_out === 32'h0, "R8 held cleared", cnt_out, 32'h0);
    @(negedge slow_clk);
    tb_prev = tb_cur; tb_cur = 32'h9; cnt_in = 32'h9;
    repeat (3) @(negedge slow_clk);
    @(negedge bus_clk);
    chk(cnt_out === 32'h9, "R1 first edge", cnt_out, 32'h9);
    chk(pulse_hi == pulse_rise, "R6 total width", pulse_hi, pulse_rise);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule